// File: doc/BRIEF.md
# Four-Mode Serial Port Controller

This block is a full-duplex serial port that sits behind a two-location register interface. One location is a control byte that holds the operating mode, the receiver enable, the multiprocessor filter enable, the ninth bits and the two completion flags. The other location is the data buffer. Writing the buffer starts a transmission. Reading it returns the last byte that was received.

There are four modes. Mode 0 is a synchronous shift mode for adding I/O through external shift registers. In this mode the data line carries eight bits LSB first and the transmit pin serves as the shift clock. Mode 1 sends and receives 10-bit asynchronous frames at a rate set by an external tick. Modes 2 and 3 use 11-bit frames that carry a programmable ninth bit. Mode 2 runs at a fixed rate derived from the block clock, and mode 3 runs at the external tick rate. In modes 2 and 3 a slave can set the filter enable. It is then woken only by frames whose ninth bit is 1, which marks them as address frames.

The asynchronous receiver works from a tick at 16 times the bit rate. It decides each bit by majority vote of the 7th, 8th and 9th samples, and it drops a frame whose start bit does not hold low.

Top module: `serial_port`

## Requirements
- R1: After reset the control byte reads 0x00, the transmit pin is high, and the data-line output enable is low.
- R2: A control write at location 0 stores all eight bits and reads back unchanged. The fields are mode [7:6], filter enable [5], receiver enable [4], transmit ninth bit [3], received ninth bit [2], transmit-done flag [1] and receive-done flag [0]. Location 1 reads the receive buffer.
- R3: In mode 0 a buffer write shifts the byte out LSB first on the data line, with output enable high. Each bit lasts M0_DIV clocks. The shift clock on the transmit pin is low for the first half of each bit and rises at mid-bit, where the data is valid. The transmit-done flag sets after the eighth bit.
- R4: Mode-0 reception runs while mode is 0, receiver enable is 1, the receive-done flag is 0 and the transmitter is idle. It drives the shift clock, samples the data line at each rising edge LSB first, and after eight bits loads the buffer and sets the receive-done flag. No new reception starts while that flag is set.
- R5: In mode 1 a buffer write sends a 10-bit frame: start 0, eight data bits LSB first, stop 1. Each bit lasts 16 ticks of the external tick. The transmit-done flag sets at the end of the stop bit.
- R6: In modes 2 and 3 the frame has 11 bits, and the transmit ninth bit is placed between the eighth data bit and the stop bit. In mode 2 a bit lasts 16*M2_DIV clocks. In mode 3 it lasts 16 external ticks.
- R7: The asynchronous receiver decides each bit by majority of samples 7, 8 and 9 of 16. On an accepted frame it loads the buffer and sets the receive-done flag. It also stores the received ninth bit: the ninth data bit in modes 2 and 3, or the stop bit in mode 1.
- R8: A start bit whose majority sample is high is discarded: the buffer and flags are unchanged, and the receiver waits for the next falling line.
- R9: With the filter enable set in mode 2 or 3, a frame whose ninth bit is 0 is discarded and one whose ninth bit is 1 is accepted. In mode 1 the filter enable has no effect.
- R10: A frame that completes while the receive-done flag is still set is discarded, and the buffer keeps its previous byte.
- R11: A buffer write while a transmission is in progress is ignored, and the frame on the line continues unchanged.
- R12: The transmit-done and receive-done flags stay set until a control write clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud16_i | input | 1 | One-clock tick at 16x the bit rate for modes 1 and 3 |
| sel_i | input | 1 | Register select: 0 control, 1 data buffer |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected location |
| rxd_i | input | 1 | Receive line, or mode-0 data line input |
| rxd_o | output | 1 | Mode-0 data line output |
| rxd_oe_o | output | 1 | Mode-0 data line output enable |
| txd_o | output | 1 | Transmit line, or mode-0 shift clock |

## Verification
The bench builds the port with M0_DIV of 8 and M2_DIV of 2, and it pulses the external tick every 4 clocks. With these values a mode-1 or mode-3 bit lasts 64 clocks, a mode-2 bit lasts 32 clocks and a mode-0 bit lasts 8 clocks. That keeps each frame short enough for the bench to cover all four modes in both directions. It also leaves room for the filter cases in modes 1, 2 and 3, an overrun, a false start and a write while the transmitter is busy, all in one short run.

// File: rtl/serial_port.sv
module serial_port #(
  parameter int M0_DIV = 12,
  parameter int M2_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud16_i,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic       txd_o
);

  localparam int M0W = $clog2(M0_DIV);
  localparam int M2W = (M2_DIV > 1) ? $clog2(M2_DIV) : 1;
  localparam logic [M0W-1:0] M0_LAST = M0W'(M0_DIV - 1);
  localparam logic [M0W-1:0] M0_MID  = M0W'(M0_DIV / 2);
  localparam logic [M2W-1:0] M2_LAST = M2W'(M2_DIV - 1);

  logic [1:0] mode;
  logic       mp_en, rx_en, tx9, rx9, ti, ri;
  logic [7:0] rx_buf;

  wire wr_ctrl = wr_i & ~sel_i;
  wire wr_buf  = wr_i & sel_i;
  wire m0      = (mode == 2'd0);
  wire eleven  = mode[1];

  assign rdata_o = sel_i ? rx_buf : {mode, mp_en, rx_en, tx9, rx9, ti, ri};

  logic [1:0] rxd_q;
  wire rxd_s = rxd_q[1];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rxd_q <= 2'b11;
    else        rxd_q <= {rxd_q[0], rxd_i};

  logic [M2W-1:0] m2_cnt;
  wire m2_tick = (m2_cnt == M2_LAST);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       m2_cnt <= '0;
    else if (m2_tick) m2_cnt <= '0;
    else              m2_cnt <= m2_cnt + 1'b1;

  wire tick = (mode == 2'd2) ? m2_tick : baud16_i;

  // transmitter
  logic           tx_busy, tx_m0, txd_r;
  logic [9:0]     tx_sh;
  logic [3:0]     tx_cnt, tx_sub;
  logic [M0W-1:0] tx_div;

  wire tx_go  = wr_buf & ~tx_busy;
  wire tx_end = tx_busy & (tx_m0 ? (tx_div == M0_LAST && tx_cnt == 4'd1)
                                 : (tick && tx_sub == 4'd15 && tx_cnt == 4'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_m0   <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_sub  <= '0;
      tx_div  <= '0;
      txd_r   <= 1'b1;
    end else if (tx_go) begin
      tx_busy <= 1'b1;
      tx_m0   <= m0;
      tx_sh   <= {1'b1, eleven ? tx9 : 1'b1, wdata_i};
      tx_cnt  <= m0 ? 4'd8 : (eleven ? 4'd10 : 4'd9);
      tx_sub  <= '0;
      tx_div  <= '0;
      txd_r   <= m0;
    end else if (tx_busy) begin
      if (tx_m0) begin
        tx_div <= (tx_div == M0_LAST) ? '0 : tx_div + 1'b1;
        if (tx_div == M0_LAST) begin
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_cnt <= tx_cnt - 1'b1;
          if (tx_cnt == 4'd1) tx_busy <= 1'b0;
        end
      end else if (tick) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == 4'd15) begin
          if (tx_cnt == 4'd0) tx_busy <= 1'b0;
          else begin
            txd_r  <= tx_sh[0];
            tx_sh  <= {1'b1, tx_sh[9:1]};
            tx_cnt <= tx_cnt - 1'b1;
          end
        end
      end
    end
  end

  // receiver
  logic           rx_run, s7, s8, rx_b9, rx_m0;
  logic [3:0]     rx_sub, rx_idx;
  logic [7:0]     rx_sh;
  logic [M0W-1:0] rx_div;
  logic [2:0]     rx_cnt;

  wire maj       = (s7 & s8) | (s7 & rxd_s) | (s8 & rxd_s);
  wire rx_samp   = rx_run & tick & (rx_sub == 4'd9);
  wire a_final   = rx_samp & (eleven ? (rx_idx == 4'd10) : (rx_idx == 4'd9));
  wire b9_fin    = eleven ? rx_b9 : maj;
  wire rx_accept = a_final & ~ri & ~(mp_en & eleven & ~b9_fin);
  wire m0_go     = m0 & rx_en & ~ri & ~tx_busy & ~rx_m0 & ~wr_buf;
  wire m0_fin    = rx_m0 & (rx_div == M0_LAST) & (rx_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_run <= 1'b0;
      rx_sub <= '0;
      rx_idx <= '0;
      s7     <= 1'b1;
      s8     <= 1'b1;
      rx_b9  <= 1'b0;
      rx_sh  <= '0;
      rx_buf <= '0;
      rx_m0  <= 1'b0;
      rx_div <= '0;
      rx_cnt <= '0;
    end else begin
      if (!rx_en || m0) rx_run <= 1'b0;
      else if (!rx_run) begin
        if (tick && !rxd_s) begin
          rx_run <= 1'b1;
          rx_sub <= '0;
          rx_idx <= '0;
        end
      end else if (tick) begin
        rx_sub <= rx_sub + 1'b1;
        if (rx_sub == 4'd15) rx_idx <= rx_idx + 1'b1;
        if (rx_sub == 4'd7)  s7 <= rxd_s;
        if (rx_sub == 4'd8)  s8 <= rxd_s;
        if (rx_sub == 4'd9) begin
          if (rx_idx == 4'd0 && maj) rx_run <= 1'b0;
          else if (rx_idx >= 4'd1 && rx_idx <= 4'd8) rx_sh <= {maj, rx_sh[7:1]};
          else if (rx_idx == 4'd9 && eleven) rx_b9 <= maj;
          if (a_final) rx_run <= 1'b0;
        end
      end

      if (m0_go) begin
        rx_m0  <= 1'b1;
        rx_div <= '0;
        rx_cnt <= '0;
      end else if (rx_m0) begin
        rx_div <= (rx_div == M0_LAST) ? '0 : rx_div + 1'b1;
        if (rx_div == M0_MID) rx_sh <= {rxd_s, rx_sh[7:1]};
        if (rx_div == M0_LAST) begin
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == 3'd7) rx_m0 <= 1'b0;
        end
      end

      if (rx_accept || m0_fin) rx_buf <= rx_sh;
    end
  end

  // control byte and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      mp_en <= 1'b0;
      rx_en <= 1'b0;
      tx9   <= 1'b0;
      rx9   <= 1'b0;
      ti    <= 1'b0;
      ri    <= 1'b0;
    end else begin
      if (wr_ctrl) {mode, mp_en, rx_en, tx9, rx9, ti, ri} <= wdata_i;
      if (tx_end) ti <= 1'b1;
      if (rx_accept) begin
        ri  <= 1'b1;
        rx9 <= b9_fin;
      end
      if (m0_fin) ri <= 1'b1;
    end
  end

  assign rxd_oe_o = tx_busy & tx_m0;
  assign rxd_o    = rxd_oe_o ? tx_sh[0] : 1'b1;
  assign txd_o    = (tx_busy & tx_m0) ? (tx_div >= M0_MID)
                  : rx_m0             ? (rx_div >= M0_MID)
                  : txd_r;

  p_oe_mode0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_oe_o) |-> $past(mode) == 2'd0);

  p_ti_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> ($past(tx_busy) || $past(wr_ctrl && wdata_i[1])));

  p_ri_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri) |-> $past(wr_ctrl));

  p_addr_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri) && mp_en && eleven && !$past(wr_ctrl)) |-> rx9);

  p_start_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_run) |-> ($past(tick) && !$past(rxd_s)));

  p_busy_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && tx_busy) |=> tx_cnt <= $past(tx_cnt));

  p_m0_rx_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_m0) |-> !$past(ri));

endmodule

// File: tb/test_serial_port.sv
module test_serial_port;
  localparam int M0 = 8;
  localparam int M2 = 2;
  localparam int T  = 4;
  localparam int BC = 16 * T;
  localparam int B2 = 16 * M2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd_i = 1'b1;
  logic       rxd_o, oe, txd;

  int n_chk = 0;
  int n_bad = 0;
  int tcnt = 0;

  serial_port #(.M0_DIV(M0), .M2_DIV(M2)) i_serial_port (
    .clk(clk), .rst_n(rst_n), .baud16_i(baud), .sel_i(sel), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd_i), .rxd_o(rxd_o),
    .rxd_oe_o(oe), .txd_o(txd));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == T - 1) ? 0 : tcnt + 1;
    baud <= (tcnt == T - 1);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk);
    sel = s;
    #1 v = rdata;
  endtask

  task automatic wait_flag(input int b, input int maxc, output bit ok);
    ok = 0;
    for (int i = 0; i < maxc && !ok; i++) begin
      @(negedge clk);
      sel = 1'b0;
      #1 if (rdata[b]) ok = 1;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v);
    chk("R1 control", v, 0);
    chk("R1 txd", txd, 1);
    chk("R1 oe", oe, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr_reg(1'b0, 8'h7C);
    rd(1'b0, v);
    chk("R2 readback", v, 8'h7C);
    wr_reg(1'b0, 8'h00);
    rd(1'b1, v);
    chk("R2 buffer read", v, 0);
  endtask

  task automatic t_m0_tx();
    logic [7:0] d = 8'hA5;
    logic [7:0] v;
    bit ok;
    time t0 = 0;
    time t1 = 0;
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, d);
    for (int i = 0; i < 8; i++) begin
      @(posedge txd);
      #1;
      if (i == 0) t0 = $time;
      if (i == 1) t1 = $time;
      if (i == 2) begin
        @(negedge clk);
        sel = 1'b1; wdata = 8'hFF; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
      end
      chk("R3 mode0 data bit", rxd_o, d[i]);
      chk("R3 mode0 oe", oe, 1);
    end
    chk("R3 bit period", int'((t1 - t0) / 20), M0);
    wait_flag(1, 4 * M0, ok);
    chk("R3 ti after byte", ok, 1);
    repeat (3 * M0) @(negedge clk);
    chk("R11 no second frame oe", oe, 0);
    chk("R11 txd idle", txd, 1);
    rd(1'b0, v);
    chk("R12 ti stays set", v[1], 1);
    wr_reg(1'b0, 8'h00);
    rd(1'b0, v);
    chk("R12 ti cleared by write", v[1], 0);
  endtask

  task automatic t_m0_rx();
    logic [7:0] d = 8'h3C;
    logic [7:0] v;
    bit ok;
    bit moved = 0;
    fork
      wr_reg(1'b0, 8'h10);
      for (int i = 0; i < 8; i++) begin
        @(negedge txd);
        rxd_i = d[i];
        #1 if (oe) moved = 1;
      end
    join
    wait_flag(0, 4 * M0, ok);
    chk("R4 ri after byte", ok, 1);
    chk("R4 line not driven", moved, 0);
    rd(1'b1, v);
    chk("R4 received byte", v, d);
    rxd_i = 1'b1;
    moved = 0;
    for (int i = 0; i < 4 * M0; i++) begin
      @(negedge clk);
      if (!txd) moved = 1;
    end
    chk("R4 no clock while ri set", moved, 0);
    wr_reg(1'b0, 8'h00);
  endtask

  task automatic t_tx_async(input string req, input logic [7:0] c, input logic [7:0] d,
                            input bit el, input bit b9, input int bc);
    bit ok = 0;
    wr_reg(1'b0, c);
    wr_reg(1'b1, d);
    for (int i = 0; i < 100 && !ok; i++) begin
      @(negedge clk);
      if (!txd) ok = 1;
    end
    chk({req, " start seen"}, ok, 1);
    repeat (bc / 2) @(negedge clk);
    chk({req, " start bit"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bc) @(negedge clk);
      chk({req, " data bit"}, txd, d[i]);
    end
    if (el) begin
      repeat (bc) @(negedge clk);
      chk({req, " ninth bit"}, txd, b9);
    end
    repeat (bc) @(negedge clk);
    chk({req, " stop bit"}, txd, 1);
    wait_flag(1, bc, ok);
    chk({req, " ti at end"}, ok, 1);
    wr_reg(1'b0, 8'h00);
  endtask

  task automatic send(input bit el, input logic [7:0] d, input bit b9, input int bc);
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      repeat (bc) @(negedge clk);
    end
    if (el) begin
      rxd_i = b9;
      repeat (bc) @(negedge clk);
    end
    rxd_i = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic t_rx(input string req, input logic [7:0] c, input bit el,
                      input logic [7:0] d, input bit b9, input int bc,
                      input bit exp_ri, input logic [7:0] exp_buf, input bit exp_b9);
    logic [7:0] v;
    wr_reg(1'b0, c);
    send(el, d, b9, bc);
    rd(1'b0, v);
    chk({req, " ri"}, v[0], exp_ri);
    chk({req, " ninth"}, v[2], exp_b9);
    rd(1'b1, v);
    chk({req, " buffer"}, v, exp_buf);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send(1'b0, 8'h77, 1'b1, BC);
    rd(1'b1, v);
    chk("R10 buffer kept", v, 8'h5A);
    rd(1'b0, v);
    chk("R10 ri still set", v[0], 1);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    wr_reg(1'b0, 8'h50);
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (4 * T) @(negedge clk);
    rxd_i = 1'b1;
    repeat (12 * BC) @(negedge clk);
    rd(1'b0, v);
    chk("R8 false start no ri", v[0], 0);
    rd(1'b1, v);
    chk("R8 buffer unchanged", v, 8'h99);
    t_rx("R8 recovers", 8'h50, 1'b0, 8'h12, 1'b1, BC, 1'b1, 8'h12, 1'b1);
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl();
    t_m0_tx();
    t_m0_rx();
    t_tx_async("R5 mode1", 8'h40, 8'h96, 1'b0, 1'b1, BC);
    t_tx_async("R6 mode2", 8'h80, 8'h3B, 1'b1, 1'b0, B2);
    t_tx_async("R6 mode3", 8'hC8, 8'hE1, 1'b1, 1'b1, BC);
    t_rx("R7 mode1 rx", 8'h50, 1'b0, 8'h5A, 1'b1, BC, 1'b1, 8'h5A, 1'b1);
    t_overrun();
    t_rx("R7 mode3 rx", 8'hD0, 1'b1, 8'hC3, 1'b0, BC, 1'b1, 8'hC3, 1'b0);
    t_rx("R9 mode3 data dropped", 8'hF0, 1'b1, 8'h44, 1'b0, BC, 1'b0, 8'hC3, 1'b0);
    t_rx("R9 mode3 address taken", 8'hF0, 1'b1, 8'h81, 1'b1, BC, 1'b1, 8'h81, 1'b1);
    t_rx("R9 mode2 data dropped", 8'hB0, 1'b1, 8'h44, 1'b0, B2, 1'b0, 8'h81, 1'b0);
    t_rx("R9 mode1 filter no effect", 8'h70, 1'b0, 8'h99, 1'b1, BC, 1'b1, 8'h99, 1'b1);
    t_glitch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule